// File: doc/BRIEF.md
# Serial Port FIFO Interrupt and DMA Request Unit

This unit watches the fill levels of the transmit and receive FIFOs of a serial peripheral interface controller. It turns them into seven raw interrupt flags, filters them through a software mask and combines the result into one interrupt line. It also raises single and burst DMA requests for both directions. The FIFO storage and the serial shifter sit outside. They supply the levels, the receive push and pop strobes and a tick once per serial clock period. The register file supplies the watermarks, the module enable and write strobes for the mask, clear and DMA-enable registers.

Two of the flags are sticky: receive overrun and receive timeout. They are set by an event and stay set until software clears them. The other five follow the FIFO state from cycle to cycle. The DMA lines follow the levels directly, gated by the module enable and a per-direction DMA enable.

Top module: `spi_irq_dma`

## Requirements
- R1: After reset both sticky flags, the mask and both DMA enables are zero, so `irq` and all four DMA request lines are low.
- R2: Raw bit 2 (receive level) is 1 exactly when `rx_level` is strictly greater than `rx_wm`.
- R3: Raw bit 3 (transmit level) is 1 exactly when `tx_level` is strictly less than `tx_wm`.
- R4: Raw bit 1 (receive timeout) becomes 1 in the cycle after the 32nd `sck_tick` during which the receive FIFO was non-empty and no `rx_pop` occurred. A pop or an empty FIFO restarts the count from zero. The flag is raised at most once per unread stretch.
- R5: Raw bit 0 (overrun) becomes 1 in the cycle after `rx_push` is asserted with `rx_level` equal to DEPTH and no `rx_pop` in the same cycle.
- R6: Bits 0 and 1 hold until a write with a 1 in that bit position, on either `clr_we` or `mask_we`, clears them one cycle later. A set event in the same cycle as such a write leaves the flag set. Writing 1 to bits 2 to 6 through the clear port has no effect.
- R7: `mask_we` loads `mask_wdata` into the mask. `masked_status` is raw AND mask, and `irq` is the OR of `masked_status`.
- R8: Raw bit 4 is 1 when the receive FIFO is not empty. Raw bit 5 is 1 when it holds DEPTH words. Raw bit 6 is 1 when the transmit FIFO is empty.
- R9: `dma_we` loads the DMA enables: bit 0 enables receive and bit 1 enables transmit. With `enable` and the receive enable set, `rx_dma_single` is 1 when at least one word is held and `rx_dma_burst` is 1 when at least 4 words are held.
- R10: With `enable` and the transmit enable set, `tx_dma_single` is 1 when at least one entry is free and `tx_dma_burst` is 1 when at least 4 entries are free.
- R11: When `enable` is low, or a direction's DMA enable is zero, that direction's two request lines are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| enable | input | 1 | Module enable |
| rx_level | input | 5 | Receive FIFO word count (0..DEPTH) |
| tx_level | input | 5 | Transmit FIFO word count (0..DEPTH) |
| rx_push | input | 1 | Shifter writes a word into the receive FIFO |
| rx_pop | input | 1 | Software or DMA reads a word from the receive FIFO |
| sck_tick | input | 1 | One pulse per serial clock period |
| rx_wm | input | 4 | Receive watermark |
| tx_wm | input | 4 | Transmit watermark |
| mask_we | input | 1 | Mask register write strobe |
| mask_wdata | input | 7 | Mask write data |
| clr_we | input | 1 | Clear register write strobe |
| clr_wdata | input | 7 | Clear write data, 1 clears |
| dma_we | input | 1 | DMA enable register write strobe |
| dma_wdata | input | 2 | DMA enables: bit 0 receive, bit 1 transmit |
| raw_status | output | 7 | Raw interrupt flags |
| masked_status | output | 7 | Raw flags after the mask |
| irq | output | 1 | Combined interrupt line |
| rx_dma_single | output | 1 | Receive single-word DMA request |
| rx_dma_burst | output | 1 | Receive burst DMA request |
| tx_dma_single | output | 1 | Transmit single-word DMA request |
| tx_dma_burst | output | 1 | Transmit burst DMA request |

## Verification
A sticky flag can get its set event and a software clear in the same cycle. That clear can come from the clear port or from a mask write. The bench provokes this twice. It asserts `rx_push` into a full FIFO while the clear port writes bit 0. It also delivers the 32nd unread serial tick while bit 1 is cleared. In both cases it expects the flag to still read 1 in the following cycle. A reference model in the bench follows the same rules, and it also confirms that an ordinary clear, with no set event, drops the flag.

// File: rtl/spi_irq_pkg.sv
package spi_irq_pkg;

  // Raw status bit positions (software decodes these)
  localparam int unsigned BIT_OVR  = 0;
  localparam int unsigned BIT_TMO  = 1;
  localparam int unsigned BIT_RXL  = 2;
  localparam int unsigned BIT_TXL  = 3;
  localparam int unsigned BIT_RXNE = 4;
  localparam int unsigned BIT_RXF  = 5;
  localparam int unsigned BIT_TXE  = 6;
  localparam int unsigned NUM_FLAGS  = 7;
  localparam int unsigned NUM_STICKY = 2;

  function automatic logic lvl_above(input int unsigned lvl, input int unsigned mark);
    return lvl > mark;
  endfunction

  function automatic logic lvl_below(input int unsigned lvl, input int unsigned mark);
    return lvl < mark;
  endfunction

  function automatic int unsigned free_slots(input int unsigned depth, input int unsigned lvl);
    return (lvl >= depth) ? 0 : depth - lvl;
  endfunction

  function automatic logic reaches(input int unsigned count, input int unsigned thr);
    return count >= thr;
  endfunction

endpackage

// File: rtl/spi_irq_sticky.sv
module spi_irq_sticky (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  output logic flag_o
);
  // set has priority over clear
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     flag_o <= 1'b0;
    else if (set_i) flag_o <= 1'b1;
    else if (clr_i) flag_o <= 1'b0;
  end
endmodule

// File: rtl/spi_irq_rx_timeout.sv
module spi_irq_rx_timeout #(
  parameter int unsigned TICKS = 32
) (
  input  logic clk,
  input  logic rst_n,
  input  logic rx_nonempty,
  input  logic rx_pop,
  input  logic sck_tick,
  output logic set_evt_o
);
  localparam int unsigned CW = $clog2(TICKS + 1);

  logic [CW-1:0] cnt_q;
  logic          restart;

  assign restart   = !rx_nonempty || rx_pop;
  // fires only on the transition to the saturation value
  assign set_evt_o = sck_tick && !restart && (cnt_q == CW'(TICKS - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                                cnt_q <= '0;
    else if (restart)                          cnt_q <= '0;
    else if (sck_tick && cnt_q != CW'(TICKS))  cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/spi_irq_dma_req.sv
module spi_irq_dma_req
  import spi_irq_pkg::*;
#(
  parameter int unsigned DEPTH = 16,
  parameter int unsigned BURST = 4,
  parameter int unsigned LVL_W = 5,
  parameter bit          IS_RX = 1'b1
) (
  input  logic             enable,
  input  logic             dma_en,
  input  logic [LVL_W-1:0] level,
  output logic             single_o,
  output logic             burst_o
);
  int unsigned avail;

  generate
    if (IS_RX) begin : g_rx
      // words waiting to be read
      always_comb avail = 32'(level);
    end else begin : g_tx
      // entries free to be written
      always_comb avail = free_slots(DEPTH, 32'(level));
    end
  endgenerate

  logic gate;
  assign gate     = enable && dma_en;
  assign single_o = gate && reaches(avail, 1);
  assign burst_o  = gate && reaches(avail, BURST);
endmodule

// File: rtl/spi_irq_dma.sv
module spi_irq_dma
  import spi_irq_pkg::*;
#(
  parameter int unsigned DEPTH     = 16,
  parameter int unsigned TMO_TICKS = 32,
  parameter int unsigned BURST     = 4,
  parameter int unsigned LVL_W     = $clog2(DEPTH + 1),
  parameter int unsigned WM_W      = $clog2(DEPTH)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 enable,
  input  logic [LVL_W-1:0]     rx_level,
  input  logic [LVL_W-1:0]     tx_level,
  input  logic                 rx_push,
  input  logic                 rx_pop,
  input  logic                 sck_tick,
  input  logic [WM_W-1:0]      rx_wm,
  input  logic [WM_W-1:0]      tx_wm,
  input  logic                 mask_we,
  input  logic [NUM_FLAGS-1:0] mask_wdata,
  input  logic                 clr_we,
  input  logic [NUM_FLAGS-1:0] clr_wdata,
  input  logic                 dma_we,
  input  logic [1:0]           dma_wdata,
  output logic [NUM_FLAGS-1:0] raw_status,
  output logic [NUM_FLAGS-1:0] masked_status,
  output logic                 irq,
  output logic                 rx_dma_single,
  output logic                 rx_dma_burst,
  output logic                 tx_dma_single,
  output logic                 tx_dma_burst
);

  // Named internal events, observed by the bound checker
  logic ovr_set_evt;
  logic tmo_set_evt;
  logic [NUM_STICKY-1:0] sticky_set;
  logic [NUM_STICKY-1:0] sticky_clr;
  logic [NUM_STICKY-1:0] sticky_q;

  logic [NUM_FLAGS-1:0] mask_q;
  logic                 rx_dma_en_q;
  logic                 tx_dma_en_q;

  assign ovr_set_evt = rx_push && !rx_pop && (rx_level == LVL_W'(DEPTH));

  spi_irq_rx_timeout #(.TICKS(TMO_TICKS)) u_tmo (
    .clk        (clk),
    .rst_n      (rst_n),
    .rx_nonempty(rx_level != '0),
    .rx_pop     (rx_pop),
    .sck_tick   (sck_tick),
    .set_evt_o  (tmo_set_evt)
  );

  assign sticky_set[BIT_OVR] = ovr_set_evt;
  assign sticky_set[BIT_TMO] = tmo_set_evt;

  generate
    for (genvar i = 0; i < NUM_STICKY; i++) begin : g_sticky
      assign sticky_clr[i] = (clr_we && clr_wdata[i]) || (mask_we && mask_wdata[i]);
      spi_irq_sticky u_flag (
        .clk   (clk),
        .rst_n (rst_n),
        .set_i (sticky_set[i]),
        .clr_i (sticky_clr[i]),
        .flag_o(sticky_q[i])
      );
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q      <= '0;
      rx_dma_en_q <= 1'b0;
      tx_dma_en_q <= 1'b0;
    end else begin
      if (mask_we) mask_q <= mask_wdata;
      if (dma_we) begin
        rx_dma_en_q <= dma_wdata[0];
        tx_dma_en_q <= dma_wdata[1];
      end
    end
  end

  always_comb begin
    raw_status           = '0;
    raw_status[BIT_OVR]  = sticky_q[BIT_OVR];
    raw_status[BIT_TMO]  = sticky_q[BIT_TMO];
    raw_status[BIT_RXL]  = lvl_above(32'(rx_level), 32'(rx_wm));
    raw_status[BIT_TXL]  = lvl_below(32'(tx_level), 32'(tx_wm));
    raw_status[BIT_RXNE] = (rx_level != '0);
    raw_status[BIT_RXF]  = (rx_level == LVL_W'(DEPTH));
    raw_status[BIT_TXE]  = (tx_level == '0);
  end

  assign masked_status = raw_status & mask_q;
  assign irq           = |masked_status;

  spi_irq_dma_req #(.DEPTH(DEPTH), .BURST(BURST), .LVL_W(LVL_W), .IS_RX(1'b1)) u_rx_dma (
    .enable  (enable),
    .dma_en  (rx_dma_en_q),
    .level   (rx_level),
    .single_o(rx_dma_single),
    .burst_o (rx_dma_burst)
  );

  spi_irq_dma_req #(.DEPTH(DEPTH), .BURST(BURST), .LVL_W(LVL_W), .IS_RX(1'b0)) u_tx_dma (
    .enable  (enable),
    .dma_en  (tx_dma_en_q),
    .level   (tx_level),
    .single_o(tx_dma_single),
    .burst_o (tx_dma_burst)
  );

endmodule

// File: rtl/spi_irq_dma_chk.sv
module spi_irq_dma_chk #(
  parameter int unsigned DEPTH = 16,
  parameter int unsigned LVL_W = 5
) (
  input logic             clk,
  input logic             rst_n,
  input logic             enable,
  input logic [LVL_W-1:0] rx_level,
  input logic             rx_push,
  input logic             rx_pop,
  input logic             sck_tick,
  input logic             mask_we,
  input logic [6:0]       mask_wdata,
  input logic             clr_we,
  input logic [6:0]       clr_wdata,
  input logic [6:0]       raw_status,
  input logic             irq,
  input logic             rx_dma_single,
  input logic             rx_dma_burst,
  input logic             tx_dma_single,
  input logic             tx_dma_burst,
  input logic             ovr_set_evt,
  input logic             tmo_set_evt
);

  p_ovr_set_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ovr_set_evt |=> raw_status[0]);

  p_ovr_cause_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(raw_status[0]) |-> $past(rx_push && rx_level == LVL_W'(DEPTH)));

  p_ovr_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (raw_status[0] && !(clr_we && clr_wdata[0]) && !(mask_we && mask_wdata[0])) |=> raw_status[0]);

  p_tmo_set_r6: assert property (@(posedge clk) disable iff (!rst_n)
    tmo_set_evt |=> raw_status[1]);

  p_tmo_cause_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(raw_status[1]) |-> $past(sck_tick && rx_level != '0 && !rx_pop));

  p_irq_source_r7: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (raw_status != '0));

  p_dma_off_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |-> !(rx_dma_single || rx_dma_burst || tx_dma_single || tx_dma_burst));

  p_rx_burst_r9: assert property (@(posedge clk) disable iff (!rst_n)
    rx_dma_burst |-> rx_dma_single);

  p_tx_burst_r10: assert property (@(posedge clk) disable iff (!rst_n)
    tx_dma_burst |-> tx_dma_single);

endmodule

bind spi_irq_dma spi_irq_dma_chk #(.DEPTH(DEPTH), .LVL_W(LVL_W)) u_chk (.*);

// File: tb/spi_irq_dma_test.sv
`timescale 1ns/1ps
module spi_irq_dma_test;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic       en = 0, push = 0, pop = 0, tick = 0;
  logic [4:0] rxl = 0, txl = 0;
  logic [3:0] rwm = 0, twm = 0;
  logic       mwe = 0, cwe = 0, dwe = 0;
  logic [6:0] mwd = 0, cwd = 0;
  logic [1:0] dwd = 0;

  logic [6:0] raw, msk;
  logic       irq, rxs, rxb, txs, txb;

  spi_irq_dma uut (
    .clk(clk), .rst_n(rst_n), .enable(en), .rx_level(rxl), .tx_level(txl),
    .rx_push(push), .rx_pop(pop), .sck_tick(tick), .rx_wm(rwm), .tx_wm(twm),
    .mask_we(mwe), .mask_wdata(mwd), .clr_we(cwe), .clr_wdata(cwd),
    .dma_we(dwe), .dma_wdata(dwd), .raw_status(raw), .masked_status(msk),
    .irq(irq), .rx_dma_single(rxs), .rx_dma_burst(rxb),
    .tx_dma_single(txs), .tx_dma_burst(txb)
  );

  typedef struct {
    string      tag;
    logic [6:0] raw;
    logic [6:0] msk;
    logic       irq;
    logic [3:0] dma;
  } item_t;

  item_t q[$];
  int n_cmp = 0, n_bad = 0;
  bit done = 0;

  // Reference model state
  logic       m_ovr = 0, m_tmo = 0, m_rxen = 0, m_txen = 0;
  logic [6:0] m_mask = 0;
  int         m_cnt = 0;

  // Monitor: compares one expected item per cycle, after the edge
  initial begin
    forever begin
      @(negedge clk); #1;
      if (q.size() > 0) begin
        item_t e;
        logic [3:0] act_dma;
        e = q.pop_front();
        act_dma = {txb, txs, rxb, rxs};
        n_cmp++;
        if (raw !== e.raw || msk !== e.msk || irq !== e.irq || act_dma !== e.dma) begin
          n_bad++;
          $display("FAIL %s: actual raw=%b msk=%b irq=%b dma=%b expected raw=%b msk=%b irq=%b dma=%b",
                   e.tag, raw, msk, irq, act_dma, e.raw, e.msk, e.irq, e.dma);
        end
      end
    end
  end

  // Driver: advances the model, pushes the expected item, runs one cycle
  task automatic cycle(input string tag);
    item_t e;
    logic rst_t, set_t, set_o, clr0, clr1;
    int   freec;
    rst_t = (rxl == 0) || pop;
    set_t = tick && !rst_t && (m_cnt == 31);
    set_o = push && !pop && (rxl == 16);
    clr0  = (cwe && cwd[0]) || (mwe && mwd[0]);
    clr1  = (cwe && cwd[1]) || (mwe && mwd[1]);
    if (set_o) m_ovr = 1; else if (clr0) m_ovr = 0;
    if (set_t) m_tmo = 1; else if (clr1) m_tmo = 0;
    if (rst_t) m_cnt = 0; else if (tick && m_cnt < 32) m_cnt++;
    if (mwe) m_mask = mwd;
    if (dwe) begin m_rxen = dwd[0]; m_txen = dwd[1]; end
    freec = 16 - int'(rxl);
    freec = 16 - int'(txl);
    e.tag = tag;
    e.raw = {txl == 0, rxl == 16, rxl != 0, int'(txl) < int'(twm), int'(rxl) > int'(rwm), m_tmo, m_ovr};
    e.msk = e.raw & m_mask;
    e.irq = (e.msk != 0);
    e.dma[0] = en && m_rxen && rxl >= 1;
    e.dma[1] = en && m_rxen && rxl >= 4;
    e.dma[2] = en && m_txen && freec >= 1;
    e.dma[3] = en && m_txen && freec >= 4;
    q.push_back(e);
    @(negedge clk); #2;
    push = 0; pop = 0; tick = 0; mwe = 0; cwe = 0; dwe = 0;
  endtask

  // Watchdog
  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); #2;
    rst_n = 1;
    cycle("R1 reset state");

    // R7 mask load
    mwe = 1; mwd = 7'h7F; cycle("R7 mask all");

    // R2 receive level flag
    rwm = 4; rxl = 4; cycle("R2 rx level equal wm");
    rxl = 5; cycle("R2 rx level above wm");
    rwm = 15; rxl = 16; cycle("R2 rx level 16 over wm 15, R8 full");

    // R3 transmit level flag
    twm = 4; txl = 4; cycle("R3 tx level equal wm");
    txl = 3; cycle("R3 tx level below wm");
    twm = 0; txl = 0; cycle("R3 wm zero never below, R8 tx empty");

    // R7 partial mask
    mwe = 1; mwd = 7'b0000100; rwm = 4; rxl = 3; cycle("R7 only rx level unmasked");
    rxl = 6; cycle("R7 irq from rx level");

    // R9 R10 R11 DMA requests
    en = 1; dwe = 1; dwd = 2'b11; rxl = 0; txl = 16; cycle("R9 R10 DMA enable write");
    rxl = 1;  txl = 15; cycle("R9 single rx, R10 single tx");
    rxl = 3;  txl = 13; cycle("R9 rx below burst, R10 tx below burst");
    rxl = 4;  txl = 12; cycle("R9 rx burst, R10 tx burst");
    rxl = 16; txl = 0;  cycle("R9 R10 extremes");
    en = 0; cycle("R11 module disabled");
    en = 1; cycle("R11 module re-enabled");
    dwe = 1; dwd = 2'b01; cycle("R11 tx DMA enable cleared");
    dwe = 1; dwd = 2'b00; cycle("R11 both DMA enables cleared");

    // R5 R6 overrun
    mwe = 1; mwd = 7'h03; rxl = 16; cycle("R7 sticky-only mask");
    push = 1; cycle("R5 push into full sets overrun");
    cycle("R6 overrun holds");
    cwe = 1; cwd = 7'h7C; cycle("R6 clear of level bits no effect");
    cwe = 1; cwd = 7'h01; cycle("R6 clear drops overrun");
    push = 1; cwe = 1; cwd = 7'h01; cycle("R6 set wins over clear");
    mwe = 1; mwd = 7'h03; cycle("R6 mask write clears overrun");
    push = 1; pop = 1; cycle("R5 push with pop no overrun");
    rxl = 15; push = 1; cycle("R5 push not full no overrun");

    // R4 timeout
    rxl = 2;
    for (int i = 0; i < 31; i++) begin
      tick = 1; cycle("R4 tick below 32");
      cycle("R4 idle gap");
    end
    tick = 1; cycle("R4 32nd tick sets timeout");
    tick = 1; cycle("R4 timeout holds");
    cwe = 1; cwd = 7'h02; cycle("R6 clear timeout");
    for (int i = 0; i < 40; i++) begin
      tick = 1; cycle("R4 saturated no second set");
    end
    pop = 1; cycle("R4 pop restarts");
    for (int i = 0; i < 20; i++) begin
      tick = 1; cycle("R4 count after pop");
    end
    pop = 1; tick = 1; cycle("R4 pop with tick restarts");
    for (int i = 0; i < 31; i++) begin
      tick = 1; cycle("R4 31 ticks no set");
    end
    rxl = 0; tick = 1; cycle("R4 empty restarts");
    rxl = 2;
    for (int i = 0; i < 31; i++) begin
      tick = 1; cycle("R4 count after empty");
    end
    tick = 1; cwe = 1; cwd = 7'h02; cycle("R6 timeout set wins over clear");
    mwe = 1; mwd = 7'h7F; cycle("R6 mask write clears timeout");
    cycle("R7 final idle");

    @(negedge clk); #3;
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule